// File: doc/BRIEF.md
# Serial Character Transmitter with Abort and Break

This block is the transmit half of an asynchronous serial channel. It walks a ring of transmit descriptors. Each descriptor names a buffer of characters. The block reads those characters one at a time into a single-entry holding register, then passes them to a shift register that puts them on the line. Bit timing comes from an external clock-enable, `tick`. Each bit occupies the interval between two consecutive ticks.

Framing is set by three inputs: parity on or off, parity sense, and the number of stop bits. These values are captured when a frame enters the shifter. A descriptor can ask for one all-ones frame before its first character, which marks the start of a message.

When a descriptor's last character has left the line, the block pulses a completion strobe and reports the descriptor's index. The surrounding memory uses that strobe to mark the descriptor as no longer ready.

A stop command aborts the message in progress. Characters already held in the holding register and the shifter still go out. After them the block sends a programmed number of break frames and then idles. The descriptor pointer does not move. A restart command resumes fetching at the same descriptor, from its first character.

Top module: `serial_tx_engine`

## Requirements
- R1: A character frame is sent least significant bit first, in this order: one start bit at 0, then DW data bits, then a parity bit when `par_en`=1, then one stop bit at 1, or two when `two_stop`=1. Each bit lasts exactly one tick interval. With even parity (`par_odd`=0), data plus parity hold an even number of ones. With odd parity (`par_odd`=1), they hold an odd number.
- R2: After reset, `txd` is 1 and `done` and `irq` are 0. While no frame is being shifted, `txd` stays 1.
- R3: The characters of a descriptor go out in buffer order, at offsets 0 to `bd_len`-1. The pointer then moves to the next descriptor index, modulo 2^PW. Consecutive frames follow one another with no gap.
- R4: When `bd_pre`=1, one all-ones frame, as long as a character frame, is sent before the descriptor's first character.
- R5: A one-cycle `done` pulse, with `done_idx` set to the descriptor, is raised at the tick that ends the last stop bit of the descriptor's last character. `irq` pulses in the same cycle only when that descriptor's `bd_intr` was 1.
- R6: After `cmd_stop`, no further characters are fetched. At most two characters already loaded are completed. Then `brk_count` break frames follow, each all zeros and as long as a character frame, and then the line idles. The aborted descriptor gets no `done`, and `bd_idx` is unchanged.
- R7: `cmd_restart` resumes fetching at the unchanged `bd_idx`, starting from offset 0 of that descriptor. The first start bit appears three cycles after the command is sampled when the tick is always high.
- R8: While the descriptor at `bd_idx` is not ready, nothing is sent and the line stays high. Once it becomes ready during run, its first start bit follows two cycles later when the tick is always high.
- R9: While `tick` is 0, `txd` does not change.
- R10: When `brk_count`=0, the line goes straight to idle after the drained characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate clock enable |
| cmd_restart | input | 1 | Start or resume fetching (pulse) |
| cmd_stop | input | 1 | Abort message, drain, then send breaks (pulse) |
| brk_count | input | BW | Number of break frames after a stop |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| bd_idx | output | PW | Current descriptor index |
| bd_ready | input | 1 | Descriptor at bd_idx holds data to send |
| bd_len | input | LW | Character count of that descriptor (at least 1) |
| bd_intr | input | 1 | Raise irq on its completion |
| bd_pre | input | 1 | Send an idle frame before its first character |
| chr_off | output | LW | Character offset being read |
| chr_data | input | DW | Character at bd_idx, chr_off |
| done | output | 1 | Descriptor completed (pulse) |
| done_idx | output | PW | Index of the completed descriptor |
| irq | output | 1 | Completion interrupt (pulse) |
| txd | output | 1 | Serial output |

## Verification
The assertions take several things about the inputs for granted. `cmd_stop` and `cmd_restart` never arrive in the same cycle. The descriptor inputs and the framing inputs stay stable while they are in use. `bd_len` is never zero. The stimulus meets these conditions: every command is a single, isolated pulse. Descriptors are written only while they are not ready, or before a restart. Framing inputs change only while the line is idle. Commands are timed against known fetch points, so that a stop lands after the second character has been loaded.

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int DW = 8,
  parameter int PW = 2,
  parameter int LW = 4,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_restart,
  input  logic          cmd_stop,
  input  logic [BW-1:0] brk_count,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  output logic [PW-1:0] bd_idx,
  input  logic          bd_ready,
  input  logic [LW-1:0] bd_len,
  input  logic          bd_intr,
  input  logic          bd_pre,
  output logic [LW-1:0] chr_off,
  input  logic [DW-1:0] chr_data,
  output logic          done,
  output logic [PW-1:0] done_idx,
  output logic          irq,
  output logic          txd
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW);

  logic          run, pre_sent;
  logic [PW-1:0] ptr;
  logic [LW-1:0] off;
  logic [BW-1:0] brk_left;

  logic          f_full, f_idle, f_last, f_intr;
  logic [DW-1:0] f_data;
  logic [PW-1:0] f_idx;

  logic          busy, s_last, s_intr;
  logic [FW-1:0] frame, cf;
  logic [CW-1:0] cnt, flen;
  logic [PW-1:0] s_idx;

  wire need_pre = bd_pre && (off == '0) && !pre_sent;
  wire push     = run && !cmd_stop && !f_full && bd_ready;
  wire fin      = busy && (cnt == flen - CW'(1));
  wire slot     = tick && (!busy || fin);
  wire brk_go   = slot && !f_full && !run && (brk_left != '0);

  assign bd_idx  = ptr;
  assign chr_off = off;
  assign txd     = busy ? frame[0] : 1'b1;

  always_comb begin
    cf = '1;
    cf[0] = 1'b0;
    cf[DW:1] = f_data;
    if (par_en) cf[DW+1] = par_odd ^ (^f_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; pre_sent <= 1'b0; ptr <= '0; off <= '0; brk_left <= '0;
    end else if (cmd_stop) begin
      run <= 1'b0; off <= '0; pre_sent <= 1'b0; brk_left <= brk_count;
    end else begin
      if (cmd_restart) begin
        run <= 1'b1; brk_left <= '0;
      end else if (brk_go) begin
        brk_left <= brk_left - BW'(1);
      end
      if (push) begin
        if (need_pre) pre_sent <= 1'b1;
        else if (off == bd_len - LW'(1)) begin
          off <= '0; pre_sent <= 1'b0; ptr <= ptr + PW'(1);
        end else off <= off + LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_full <= 1'b0; f_idle <= 1'b0; f_last <= 1'b0; f_intr <= 1'b0;
      f_data <= '0; f_idx <= '0;
    end else if (push) begin
      f_full <= 1'b1;
      f_idle <= need_pre;
      f_last <= !need_pre && (off == bd_len - LW'(1));
      f_intr <= bd_intr;
      f_data <= chr_data;
      f_idx  <= ptr;
    end else if (slot) begin
      f_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '1; cnt <= '0; flen <= CW'(DW + 2);
      s_last <= 1'b0; s_intr <= 1'b0; s_idx <= '0;
      done <= 1'b0; irq <= 1'b0; done_idx <= '0;
    end else begin
      done <= slot && fin && s_last;
      irq  <= slot && fin && s_last && s_intr;
      if (slot && fin) done_idx <= s_idx;
      if (slot) begin
        cnt  <= '0;
        flen <= CW'(DW + 2) + CW'(par_en) + CW'(two_stop);
        if (f_full) begin
          busy <= 1'b1; frame <= f_idle ? '1 : cf;
          s_last <= f_last; s_intr <= f_intr; s_idx <= f_idx;
        end else if (brk_go) begin
          busy <= 1'b1; frame <= '0; s_last <= 1'b0;
        end else begin
          busy <= 1'b0; frame <= '1;
        end
      end else if (tick && busy) begin
        frame <= {1'b1, frame[FW-1:1]};
        cnt   <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/serial_tx_engine_chk.sv
module serial_tx_engine_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cmd_stop,
  input logic          cmd_restart,
  input logic          txd,
  input logic          done,
  input logic          irq,
  input logic          push,
  input logic          run,
  input logic [PW-1:0] bd_idx
);
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd)); // R9
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R5
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick)); // R5
  AST_NO_FETCH_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_stop) |-> !push); // R6
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd_restart) |=> $stable(bd_idx)); // R6
endmodule

bind serial_tx_engine serial_tx_engine_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_stop(cmd_stop),
  .cmd_restart(cmd_restart), .txd(txd), .done(done), .irq(irq),
  .push(push), .run(run), .bd_idx(bd_idx)
);

// File: tb/serial_tx_engine_test.sv
module serial_tx_engine_test;
  logic clk = 0, rst_n = 0, tick = 1, cmd_restart = 0, cmd_stop = 0;
  logic [3:0] brk_count = 0;
  logic par_en = 0, par_odd = 0, two_stop = 0;
  logic [1:0] bd_idx, done_idx;
  logic [3:0] chr_off;
  logic done, irq, txd;

  logic       rdy [4];
  logic [3:0] len [4];
  logic       intr[4];
  logic       pre [4];
  logic [7:0] dat [4][16];

  int vecs = 0, errs = 0;
  bit mon_en = 0;
  bit    exp_q[$];
  string exp_t[$];
  int    dq[$];

  always #2 clk = ~clk;

  serial_tx_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_restart(cmd_restart),
    .cmd_stop(cmd_stop), .brk_count(brk_count), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .bd_idx(bd_idx),
    .bd_ready(rdy[bd_idx]), .bd_len(len[bd_idx]), .bd_intr(intr[bd_idx]),
    .bd_pre(pre[bd_idx]), .chr_off(chr_off), .chr_data(dat[bd_idx][chr_off]),
    .done(done), .done_idx(done_idx), .irq(irq), .txd(txd));

  always @(posedge clk) if (rst_n && done) rdy[done_idx] <= 1'b0;

  task automatic check(input bit ok, input string r, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    if (exp_q.size() != 0) begin
      bit b; string t;
      b = exp_q.pop_front(); t = exp_t.pop_front();
      check(txd == b, t, txd, b);
    end else check(txd == 1'b1, "R2 idle line", txd, 1);
    if (done) begin
      if (dq.size() == 0) check(0, "R6 unexpected done", done_idx, -1);
      else begin
        int e; e = dq.pop_front();
        check({irq, done_idx} == e[2:0], "R5 done idx/irq", {irq, done_idx}, e);
      end
    end else check(irq == 1'b0, "R5 irq without done", irq, 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic lead(input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(1'b1); exp_t.push_back("R7/R8 latency"); end
  endtask

  task automatic put(input bit b, input string t);
    exp_q.push_back(b); exp_t.push_back(t);
  endtask

  task automatic push_frame(input logic [7:0] d, input string t);
    put(1'b0, t);
    for (int i = 0; i < 8; i++) put(d[i], t);
    if (par_en) put((^d) ^ par_odd, t);
    put(1'b1, t);
    if (two_stop) put(1'b1, t);
  endtask

  task automatic push_fill(input bit v, input string t);
    for (int i = 0; i < 10 + par_en + two_stop; i++) put(v, t);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
    step(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin rdy[i] = 0; len[i] = 1; intr[i] = 0; pre[i] = 0; end
    for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) dat[i][j] = 8'(i * 16 + j);
    step(3);
    rst_n = 1;
    step(1);
    check(txd == 1 && done == 0 && irq == 0, "R2 reset state", {txd, done, irq}, 3'b100);
    mon_en = 1;
    step(4);

    // R1 R3 R4 R5 R7: two descriptors, second with pre-idle
    len[0] = 2; intr[0] = 1; dat[0][0] = 8'hA5; dat[0][1] = 8'h3C; rdy[0] = 1;
    len[1] = 1; intr[1] = 0; pre[1] = 1; dat[1][0] = 8'h81; rdy[1] = 1;
    cmd_restart = 1; lead(3);
    push_frame(8'hA5, "R1 char"); push_frame(8'h3C, "R3 order");
    push_fill(1'b1, "R4 pre idle"); push_frame(8'h81, "R3 next desc");
    dq.push_back(3'b100); dq.push_back(3'b001);
    step(1); cmd_restart = 0;
    drain();
    check(bd_idx == 2, "R3 pointer advance", bd_idx, 2);
    step(20); // R8 not ready: monitor expects idle

    // R1 even parity, two stops
    par_en = 1; par_odd = 0; two_stop = 1;
    len[2] = 3; intr[2] = 1; pre[1] = 0;
    dat[2][0] = 8'h07; dat[2][1] = 8'h00; dat[2][2] = 8'hFF;
    rdy[2] = 1; lead(2);
    push_frame(8'h07, "R1 even parity"); push_frame(8'h00, "R1 even parity");
    push_frame(8'hFF, "R1 two stop");
    dq.push_back(3'b110);
    drain();

    // R1 odd parity
    par_odd = 1; two_stop = 0;
    len[3] = 1; intr[3] = 1; dat[3][0] = 8'h01; rdy[3] = 1; lead(2);
    push_frame(8'h01, "R1 odd parity");
    dq.push_back(3'b111);
    drain();

    // R6 stop with two breaks
    par_en = 0; par_odd = 0; brk_count = 2;
    len[0] = 6; intr[0] = 1; pre[0] = 0;
    for (int j = 0; j < 6; j++) dat[0][j] = 8'(8'h11 * (j + 1));
    rdy[0] = 1; lead(2);
    push_frame(8'h11, "R6 drained shifter"); push_frame(8'h22, "R6 drained fifo");
    push_fill(1'b0, "R6 break"); push_fill(1'b0, "R6 break");
    step(4); cmd_stop = 1; step(1); cmd_stop = 0;
    drain();
    check(bd_idx == 0, "R6 pointer kept", bd_idx, 0);
    step(30);

    // R7 restart resends whole message from offset 0
    brk_count = 0;
    cmd_restart = 1; lead(3);
    for (int j = 0; j < 6; j++) push_frame(8'(8'h11 * (j + 1)), "R7 resume");
    dq.push_back(3'b100);
    step(1); cmd_restart = 0;
    drain();
    check(bd_idx == 1, "R7 pointer after resume", bd_idx, 1);

    // R10 stop with zero breaks
    len[1] = 4; intr[1] = 1; dat[1][0] = 8'h5A; dat[1][1] = 8'hC3; rdy[1] = 1; lead(2);
    push_frame(8'h5A, "R10 drain"); push_frame(8'hC3, "R10 drain");
    step(4); cmd_stop = 1; step(1); cmd_stop = 0;
    drain();
    check(bd_idx == 1, "R10 pointer kept", bd_idx, 1);
    step(20);

    // R9 line holds while tick low
    mon_en = 0;
    step(1);
    cmd_restart = 1; step(1); cmd_restart = 0;
    while (txd != 1'b0) @(negedge clk);
    tick = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(txd == 1'b0, "R9 hold without tick", txd, 0);
    end
    tick = 1;
    step(5);
    check(dq.size() == 0, "R5 missing done", dq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule